// File: doc/BRIEF.md
# Next Program Counter Selector

This combinational block works out the address of the next instruction. Its inputs are the current program counter, the low part of the fetched instruction word, two decoded control lines (a conditional branch request and an unconditional jump request) and the zero flag from the ALU. It forms three candidates in parallel: the sequential address, a branch target and a jump target. It then picks one of them and drives the pick to the program counter register, which lies outside this block.

The sequential candidate is the current address plus one instruction word (4 bytes). The branch candidate uses the 16-bit immediate. The immediate is sign-extended and then scaled from words to bytes. The result is added to the sequential address, not to the current address. The jump candidate involves no adder. It joins three pieces: the top four bits of the sequential address, the 26-bit index field from the instruction, and two zero bits. A jump request wins over a branch. A branch is taken only when its request and the zero flag are both high.

All sums wrap modulo 2^32. Overflow is not reported.

Top module: `npc_unit`

## Requirements
- R1: With is_branch=0 and is_jump=0, pc_next equals pc_cur+4.
- R2: With is_branch=1, alu_zero=1 and is_jump=0, pc_next equals pc_cur+4+(offset×4). The offset is instr_idx[15:0], read as a two's-complement number.
- R3: When bit 15 of the offset is 1, that bit is copied into all 16 upper bits, so the target lies below pc_cur+4. For example, offset 0xFFFF gives pc_cur.
- R4: With is_branch=1, alu_zero=0 and is_jump=0, pc_next equals pc_cur+4.
- R5: With is_branch=0, alu_zero has no effect on pc_next.
- R6: With is_jump=1, pc_next equals {(pc_cur+4)[31:28], instr_idx[25:0], 2'b00}.
- R7: is_jump=1 selects the jump target even when is_branch=1 and alu_zero=1.
- R8: All additions wrap modulo 2^32. For example, pc_cur=0xFFFFFFFC with no branch and no jump gives 0x00000000.
- R9: The top four bits of the jump target come from pc_cur+4, not from pc_cur. A carry into bit 28 changes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_cur | input | 32 | Address of the current instruction |
| instr_idx | input | 26 | Low 26 bits of the instruction word. Bits 15:0 hold the branch offset, and all 26 bits form the jump index |
| is_branch | input | 1 | Conditional branch request from the decoder |
| is_jump | input | 1 | Unconditional jump request from the decoder |
| alu_zero | input | 1 | ALU zero flag from comparing the two registers |
| pc_next | output | 32 | Selected next address for the program counter register |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit offset, a 26-bit jump index and a 2-bit word shift. With these widths, one directed address can wrap past the top of the address space. Another can carry into the four region bits that the jump target takes from the sequential address. Both positive and negative offsets are applied at their extreme values.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
  parameter int ADDR_W = 32,
  parameter int WORD_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] pc_in,
  output logic [ADDR_W-1:0] pc_plus
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << WORD_SHIFT;

  always_comb begin
    pc_plus = pc_in + STEP;
  end

  always_comb begin
    AST_INCR_LOW_KEPT: assert (pc_plus[WORD_SHIFT-1:0] == pc_in[WORD_SHIFT-1:0]); // R1
  end
endmodule

// File: rtl/npc_branch_tgt.sv
module npc_branch_tgt #(
  parameter int ADDR_W = 32,
  parameter int IMM_W = 16,
  parameter int WORD_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  offs_words,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] offs_ext;
  logic [ADDR_W-1:0] offs_bytes;

  always_comb begin
    offs_ext   = {{EXT_W{offs_words[IMM_W-1]}}, offs_words};
    offs_bytes = offs_ext << WORD_SHIFT;
    target     = base + offs_bytes;
  end

  always_comb begin
    AST_BR_ALIGN_KEPT: assert (target[WORD_SHIFT-1:0] == base[WORD_SHIFT-1:0]); // R2
  end
endmodule

// File: rtl/npc_jump_tgt.sv
module npc_jump_tgt #(
  parameter int ADDR_W = 32,
  parameter int JIDX_W = 26,
  parameter int WORD_SHIFT = 2,
  localparam int REGION_W = ADDR_W - JIDX_W - WORD_SHIFT
) (
  input  logic [REGION_W-1:0] region,
  input  logic [JIDX_W-1:0]   index,
  output logic [ADDR_W-1:0]   target
);
  always_comb begin
    target = {region, index, {WORD_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int ADDR_W = 32,
  parameter int IMM_W = 16,
  parameter int JIDX_W = 26,
  parameter int WORD_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [JIDX_W-1:0] instr_idx,
  input  logic              is_branch,
  input  logic              is_jump,
  input  logic              alu_zero,
  output logic [ADDR_W-1:0] pc_next
);
  import npc_pkg::*;

  localparam int REGION_W = ADDR_W - JIDX_W - WORD_SHIFT;

  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] br_addr;
  logic [ADDR_W-1:0] jmp_addr;
  npc_sel_e          sel;

  npc_incr #(.ADDR_W(ADDR_W), .WORD_SHIFT(WORD_SHIFT)) u_incr (
    .pc_in  (pc_cur),
    .pc_plus(seq_addr)
  );

  npc_branch_tgt #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .WORD_SHIFT(WORD_SHIFT)) u_br (
    .base      (seq_addr),
    .offs_words(instr_idx[IMM_W-1:0]),
    .target    (br_addr)
  );

  npc_jump_tgt #(.ADDR_W(ADDR_W), .JIDX_W(JIDX_W), .WORD_SHIFT(WORD_SHIFT)) u_jmp (
    .region(seq_addr[ADDR_W-1 -: REGION_W]),
    .index (instr_idx),
    .target(jmp_addr)
  );

  always_comb begin
    if (is_jump)                    sel = NPC_JUMP;
    else if (is_branch && alu_zero) sel = NPC_BRANCH;
    else                            sel = NPC_SEQ;
  end

  always_comb begin
    unique case (sel)
      NPC_JUMP:   pc_next = jmp_addr;
      NPC_BRANCH: pc_next = br_addr;
      default:    pc_next = seq_addr;
    endcase
  end

  always_comb begin
    if (!is_branch && !is_jump)
      AST_NOBR_SEQ: assert (pc_next == seq_addr); // R5
    if (is_jump)
      AST_JUMP_OVERRIDES: assert (pc_next == jmp_addr); // R7
    if (is_jump)
      AST_JUMP_ALIGNED: assert (pc_next[WORD_SHIFT-1:0] == '0); // R6
    if (is_jump)
      AST_JUMP_REGION: assert (pc_next[ADDR_W-1 -: REGION_W] == seq_addr[ADDR_W-1 -: REGION_W]); // R9
  end
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] pc_cur;
  logic [25:0] instr_idx;
  logic        is_branch;
  logic        is_jump;
  logic        alu_zero;
  logic [31:0] pc_next;

  int checks;
  int fails;
  bit done;

  npc_unit dut (
    .pc_cur   (pc_cur),
    .instr_idx(instr_idx),
    .is_branch(is_branch),
    .is_jump  (is_jump),
    .alu_zero (alu_zero),
    .pc_next  (pc_next)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic apply(input logic [31:0] pc, input logic [25:0] idx,
                       input logic br, input logic jp, input logic z);
    @(negedge clk);
    pc_cur = pc; instr_idx = idx; is_branch = br; is_jump = jp; alu_zero = z;
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (pc_next !== exp) begin
      fails++;
      $display("FAIL %s: pc_next=%08h expected %08h", req, pc_next, exp);
    end
  endtask

  task automatic t_reset_state;
    apply(32'h0, 26'h0, 1'b0, 1'b0, 1'b0);
    check("R1", 32'h4);
  endtask

  task automatic t_sequential;
    apply(32'h0040_1000, 26'h3FF_FFFF, 1'b0, 1'b0, 1'b0);
    check("R1", 32'h0040_1004);
  endtask

  task automatic t_branch_fwd;
    apply(32'h0040_0000, 26'h000_0010, 1'b1, 1'b0, 1'b1);
    check("R2", 32'h0040_0044);
    apply(32'h1000_0000, 26'h000_7FFF, 1'b1, 1'b0, 1'b1);
    check("R2", 32'h1002_0000);
  endtask

  task automatic t_branch_back;
    apply(32'h0040_0100, 26'h000_FFFF, 1'b1, 1'b0, 1'b1);
    check("R3", 32'h0040_0100);
    apply(32'h0040_0000, 26'h000_8000, 1'b1, 1'b0, 1'b1);
    check("R3", 32'h003E_0004);
  endtask

  task automatic t_branch_not_taken;
    apply(32'h0040_0000, 26'h000_0010, 1'b1, 1'b0, 1'b0);
    check("R4", 32'h0040_0004);
  endtask

  task automatic t_zero_ignored;
    apply(32'h0000_2000, 26'h000_0040, 1'b0, 1'b0, 1'b1);
    check("R5", 32'h0000_2004);
    apply(32'h0000_2000, 26'h000_0040, 1'b0, 1'b0, 1'b0);
    check("R5", 32'h0000_2004);
  endtask

  task automatic t_jump;
    apply(32'h4000_0010, 26'h012_3456, 1'b0, 1'b1, 1'b0);
    check("R6", 32'h4048_D158);
  endtask

  task automatic t_jump_over_branch;
    apply(32'h4000_0010, 26'h000_0008, 1'b1, 1'b1, 1'b1);
    check("R7", 32'h4000_0020);
  endtask

  task automatic t_wrap;
    apply(32'hFFFF_FFFC, 26'h0, 1'b0, 1'b0, 1'b0);
    check("R8", 32'h0000_0000);
    apply(32'hFFFF_FFF0, 26'h000_0010, 1'b1, 1'b0, 1'b1);
    check("R8", 32'h0000_0034);
  endtask

  task automatic t_region_carry;
    apply(32'h0FFF_FFFC, 26'h000_0001, 1'b0, 1'b1, 1'b0);
    check("R9", 32'h1000_0004);
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0;
    pc_cur = '0; instr_idx = '0; is_branch = 0; is_jump = 0; alu_zero = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_sequential();
    t_branch_fwd();
    t_branch_back();
    t_branch_not_taken();
    t_zero_ignored();
    t_jump();
    t_jump_over_branch();
    t_wrap();
    t_region_carry();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule